// File: doc/BRIEF.md
# Double-Buffered 14-Bit DAC Word Loader

This block is the digital front end of a 14-bit digital-to-analog converter that sits on a full 14-bit data bus. Two active-low byte selects pick what a write stores. One covers the upper six bits and one covers the lower eight. A shared active-low write strobe stores the bus into the selected input registers. A separate active-low load input copies both input registers into the DAC register, which drives the converter code. The two selects are independent, so both halves can be written in a single write. Holding every control low makes the path from bus to converter code transparent.

The load input may come from outside the clock domain. It passes through a synchronizer with a parameterized number of flops. While its synchronized level is low, the DAC register takes a new value on every clock. Several instances can share one load line. Software fills each instance's input registers in turn, and a single load pulse then moves every output on the same clock edge. When a byte write and a transfer fall on the same clock edge, the DAC register takes the freshly written byte.

Top module: `dac_word_loader`

## Requirements
- R1: A rising clock edge with wr_n=0, sel_hi_n=0 and sel_lo_n=1 stores bus_data[13:8] into the upper input register and leaves the lower one unchanged.
- R2: A rising clock edge with wr_n=0, sel_lo_n=0 and sel_hi_n=1 stores bus_data[7:0] into the lower input register and leaves the upper one unchanged.
- R3: A rising clock edge with wr_n=0 and both selects low stores all 14 bus bits into the two input registers at once.
- R4: While the synchronized load level is low, the DAC register takes {upper, lower} on each edge, whatever the write strobe does while both selects are high.
- R5: With both selects, wr_n and load_n held low, dac_code follows bus_data with one clock of latency once the load level has crossed the synchronizer.
- R6: With wr_n high, or with both selects high, the input registers do not change. With load_n high, dac_code does not change.
- R7: If a byte write happens on an edge where a transfer also happens, dac_code takes the value just written for that byte and the held value for the other byte.
- R8: load_n is first sampled low at edge k. With the default two synchronizer stages, dac_code still holds its old value after edge k+1 and shows the transferred value after edge k+2.
- R9: A synchronous active-high rst clears both input registers and dac_code to zero on the next edge, and it also returns the synchronizer to the inactive (high) level.
- R10: Instances that share one load_n line but have separate selects can be filled one at a time, and a single load pulse updates all their outputs on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 14 | Data bus; the upper byte is bits 13:8 and the lower byte is bits 7:0 |
| sel_hi_n | input | 1 | Upper byte select, active low |
| sel_lo_n | input | 1 | Lower byte select, active low |
| wr_n | input | 1 | Write strobe, active low, sampled on the clock |
| load_n | input | 1 | Load to DAC register, active low; may be asynchronous |
| dac_code | output | 14 | DAC register contents (converter code) |

## Verification
The assertions assume that bus_data, the selects and wr_n are synchronous to clk and are sampled as levels on each edge. The write strobe therefore counts as one write per clock it is held low, not as a single event. The bench changes these inputs only on falling edges. It changes load_n on falling edges as well, so the synchronizer never sees a metastable sample and the transfer edge can be predicted exactly. When load_n goes low around a write, the bench keeps it low until after the write strobe has risen, as the pulse rule requires.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    localparam int HI_BITS    = 6;
    localparam int LO_BITS    = 8;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        WOP_IDLE = 2'd0,
        WOP_HI   = 2'd1,
        WOP_LO   = 2'd2,
        WOP_BOTH = 2'd3
    } wr_op_e;

    // Decode of the byte selects under the write strobe (all active low)
    function automatic wr_op_e decode_wr(input logic hi_n, input logic lo_n, input logic w_n);
        wr_op_e op;
        if (w_n) begin
            op = WOP_IDLE;
        end else begin
            case ({hi_n, lo_n})
                2'b00:   op = WOP_BOTH;
                2'b01:   op = WOP_HI;
                2'b10:   op = WOP_LO;
                default: op = WOP_IDLE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/dacw_sync.sv
module dacw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_n;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_comb begin
                chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= chain_d;
    end

    assign sync_n = chain_q[STAGES-1];

    // R9: reset returns the load level to inactive
    p_sync_reset_r9: assert property (@(posedge clk) rst |=> sync_n);
endmodule

// File: rtl/dacw_input_bank.sv
module dacw_input_bank
    import dacw_pkg::*;
#(
    parameter int HI_W = HI_BITS,
    parameter int LO_W = LO_BITS,
    localparam int W   = HI_W + LO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus,
    input  logic         hi_n,
    input  logic         lo_n,
    input  logic         w_n,
    output logic [W-1:0] word_next
);
    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } bank_t;

    bank_t  st_d, st_q;
    wr_op_e op;

    always_comb begin
        st_d = st_q;
        op   = decode_wr(hi_n, lo_n, w_n);
        if (op == WOP_HI || op == WOP_BOTH) st_d.hi = bus[W-1:LO_W];
        if (op == WOP_LO || op == WOP_BOTH) st_d.lo = bus[LO_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Next value is forwarded so a same-edge transfer sees the new byte
    assign word_next = st_d;

    // R1 / R3: upper byte captured under its select
    p_hi_load_r1: assert property (@(posedge clk) disable iff (rst)
        (!w_n && !hi_n) |=> st_q.hi == $past(bus[W-1:LO_W]));
    // R2 / R3: lower byte captured under its select
    p_lo_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!w_n && !lo_n) |=> st_q.lo == $past(bus[LO_W-1:0]));
    // R6: no write, no change
    p_hi_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (w_n || hi_n) |=> $stable(st_q.hi));
    p_lo_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (w_n || lo_n) |=> $stable(st_q.lo));
    // R9: reset clears the input registers
    p_bank_reset_r9: assert property (@(posedge clk) rst |=> st_q == '0);
endmodule

// File: rtl/dacw_dac_reg.sv
module dacw_dac_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         xfer,
    input  logic [W-1:0] src_next,
    output logic [W-1:0] code
);
    logic [W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (xfer) code_d = src_next;
    end

    always_ff @(posedge clk) begin
        if (rst) code_q <= '0;
        else     code_q <= code_d;
    end

    assign code = code_q;

    // R4 / R7: a transfer takes the forwarded input word
    p_xfer_load_r4: assert property (@(posedge clk) disable iff (rst)
        xfer |=> code_q == $past(src_next));
    // R6: without a transfer the code holds
    p_code_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(code_q));
    // R9: reset clears the code
    p_code_reset_r9: assert property (@(posedge clk) rst |=> code_q == '0);
endmodule

// File: rtl/dac_word_loader.sv
module dac_word_loader
    import dacw_pkg::*;
#(
    parameter int HI_W   = HI_BITS,
    parameter int LO_W   = LO_BITS,
    parameter int STAGES = SYNC_DEPTH,
    localparam int W     = HI_W + LO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [13:0]  bus_data,
    input  logic         sel_hi_n,
    input  logic         sel_lo_n,
    input  logic         wr_n,
    input  logic         load_n,
    output logic [13:0]  dac_code
);
    logic         load_sync_n;
    logic [W-1:0] word_next;
    logic [W-1:0] code;

    dacw_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (load_n),
        .sync_n  (load_sync_n)
    );

    dacw_input_bank #(.HI_W(HI_W), .LO_W(LO_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus_data),
        .hi_n      (sel_hi_n),
        .lo_n      (sel_lo_n),
        .w_n       (wr_n),
        .word_next (word_next)
    );

    dacw_dac_reg #(.W(W)) u_dac (
        .clk      (clk),
        .rst      (rst),
        .xfer     (!load_sync_n),
        .src_next (word_next),
        .code     (code)
    );

    assign dac_code = code;

    // R5: fully transparent once the load level has settled low
    p_transparent_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_sync_n && !sel_hi_n && !sel_lo_n && !wr_n) |=> dac_code == $past(bus_data));
endmodule

// File: tb/dac_word_loader_test.sv
module dac_word_loader_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [13:0] data;
    logic        hi_n, lo_n, hi2_n, lo2_n, wr_n, ld_n;
    logic [13:0] dac, dac2;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    typedef struct {
        int          at;
        int          inst;
        logic [13:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dac_word_loader uut (
        .clk(clk), .rst(rst), .bus_data(data), .sel_hi_n(hi_n), .sel_lo_n(lo_n),
        .wr_n(wr_n), .load_n(ld_n), .dac_code(dac)
    );
    dac_word_loader uut2 (
        .clk(clk), .rst(rst), .bus_data(data), .sel_hi_n(hi2_n), .sel_lo_n(lo2_n),
        .wr_n(wr_n), .load_n(ld_n), .dac_code(dac2)
    );

    task automatic expect_at(input int at, input int inst, input logic [13:0] v, input string tag);
        exp_t e;
        e.at = at; e.inst = inst; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares scoreboard items on the cycle they fall due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            logic [13:0] act;
            e = sb.pop_front();
            act = (e.inst == 0) ? dac : dac2;
            checks++;
            if (e.at != cyc) begin
                errors++;
                $display("FAIL %s: missed cycle %0d actual %h expected %h", e.tag, e.at, act, e.val);
            end else if (act !== e.val) begin
                errors++;
                $display("FAIL %s: cycle %0d inst %0d actual %h expected %h", e.tag, cyc, e.inst, act, e.val);
            end
        end
    end

    task automatic idle_ctl();
        hi_n = 1'b1; lo_n = 1'b1; hi2_n = 1'b1; lo2_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_word(input logic h, input logic l, input logic h2, input logic l2,
                           input logic [13:0] d);
        @(negedge clk);
        hi_n = h; lo_n = l; hi2_n = h2; lo2_n = l2; wr_n = 1'b0; data = d;
        @(negedge clk);
        idle_ctl();
    endtask

    // One-cycle load pulse; returns the cycle index at which it was driven
    task automatic ld_start(output int c0);
        @(negedge clk);
        ld_n = 1'b0;
        c0 = cyc;
    endtask

    task automatic ld_end();
        @(negedge clk);
        ld_n = 1'b1;
        wait_n(3);
    endtask

    initial begin
        int c0;
        int c;
        logic [13:0] dv [0:7];
        rst = 1'b1; data = '0; ld_n = 1'b1;
        idle_ctl();
        wait_n(3);
        rst = 1'b0;
        expect_at(cyc + 1, 0, 14'h0000, "R9");
        expect_at(cyc + 1, 1, 14'h0000, "R9");
        wait_n(2);

        // R1: upper byte only; R6: no transfer while load high
        wr_word(1'b0, 1'b1, 1'b1, 1'b1, 14'h2A55);
        expect_at(cyc + 1, 0, 14'h0000, "R6");
        wait_n(2);

        // R2: lower byte only, then transfer; R8 latency
        wr_word(1'b1, 1'b0, 1'b1, 1'b1, 14'h3FC3);
        ld_start(c0);
        expect_at(c0 + 2, 0, 14'h0000, "R8");
        expect_at(c0 + 3, 0, 14'h2AC3, "R1");
        expect_at(c0 + 3, 0, 14'h2AC3, "R2");
        expect_at(c0 + 3, 0, 14'h2AC3, "R8");
        ld_end();

        // R3: both bytes in one write
        wr_word(1'b0, 1'b0, 1'b1, 1'b1, 14'h1234);
        expect_at(cyc + 1, 0, 14'h2AC3, "R6");
        wait_n(1);
        ld_start(c0);
        expect_at(c0 + 3, 0, 14'h1234, "R3");
        ld_end();

        // R6: selects low with write high; R4: write low with selects high during load
        @(negedge clk);
        hi_n = 1'b0; lo_n = 1'b0; wr_n = 1'b1; data = 14'h3FFF;
        ld_start(c0);
        idle_ctl();
        wr_n = 1'b0;
        expect_at(c0 + 3, 0, 14'h1234, "R4");
        expect_at(c0 + 3, 0, 14'h1234, "R6");
        @(negedge clk);
        ld_n = 1'b1; wr_n = 1'b1;
        wait_n(3);

        // R5: everything low, data changes every cycle
        @(negedge clk);
        for (int i = 0; i < 8; i++) dv[i] = 14'((i * 1237 + 5) % 16384);
        hi_n = 1'b0; lo_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0; data = dv[0];
        c = cyc;
        for (int i = 2; i < 8; i++) expect_at(c + i + 1, 0, dv[i], "R5");
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            data = dv[i];
        end
        @(negedge clk);
        idle_ctl(); data = '0;
        // R7: write the lower byte while the transfer is still active
        @(negedge clk);
        lo_n = 1'b0; wr_n = 1'b0; data = 14'h00AB;
        expect_at(cyc + 1, 0, {dv[7][13:8], 8'hAB}, "R7");
        @(negedge clk);
        idle_ctl();
        @(negedge clk);
        ld_n = 1'b1;
        wait_n(4);

        // R10: fill each instance in turn, then one shared load pulse
        wr_word(1'b0, 1'b0, 1'b1, 1'b1, 14'h0101);
        wr_word(1'b1, 1'b1, 1'b0, 1'b0, 14'h3ABC);
        expect_at(cyc + 1, 1, 14'h0000, "R10");
        wait_n(1);
        ld_start(c0);
        expect_at(c0 + 2, 1, 14'h0000, "R10");
        expect_at(c0 + 3, 0, 14'h0101, "R10");
        expect_at(c0 + 3, 1, 14'h3ABC, "R10");
        ld_end();

        // R9: reset in mid-run clears loaded codes
        @(negedge clk);
        rst = 1'b1;
        expect_at(cyc + 1, 0, 14'h0000, "R9");
        expect_at(cyc + 1, 1, 14'h0000, "R9");
        @(negedge clk);
        rst = 1'b0;
        wait_n(3);

        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule